// File: doc/BRIEF.md
# Sub-word to word register access adapter

This block sits between a byte-addressed register window of 128 bytes and back-end register files that only take aligned 32-bit transfers. A requester presents an address, an access size of one, two or four bytes and, for writes, the data. All data is little-endian. The adapter turns every access into whole-word operations on one of three back-end targets: a core register file, a DMA register file and a single control register.

A full aligned word write goes straight through as one registered write strobe. A write that is narrower than a word, or that starts off a word boundary, becomes a read-modify-write. The adapter stalls the request port for one cycle and reads the current word through the back-end read port. It then replaces only the written byte lanes and issues one aligned word write. A read fetches the aligned word, shifts the addressed byte down to lane 0 and masks the result to the access size. Writes to holes in the map are dropped, and reads from holes return zero.

The back-end files have combinational read ports, indexed by `rd_idx`, and one shared registered write bus with a strobe for each target.

Top module: `subword_reg_bridge`

## Requirements
- R1: While reset is held and in the cycle after it is released, `req_ready` is 1, `rsp_valid` is 0 and none of `core_wr_en`, `dma_wr_en`, `ctl_wr_en` is set.
- R2: An accepted write with `req_size` of 2 or 3 (4 bytes) and `req_addr[1:0]` = 0 to a mapped word raises the target strobe in the cycle after acceptance. `wr_data` equals the request data unchanged, and `req_ready` stays 1 in that cycle.
- R3: The word write target is chosen from the word-aligned address. 0x00–0x3F goes to the core file with `wr_idx` = address bits [5:2]. 0x40–0x5F goes to the DMA file with `wr_idx` = (address − 0x40)/4. 0x70–0x73 goes to the control register with `wr_idx` = 0. At most one strobe is set in any cycle.
- R4: An accepted write that is not a full aligned word drives `req_ready` to 0 and sets no strobe in the next cycle. The write strobe comes one cycle later, two cycles after acceptance.
- R5: For such a merged write the new word keeps the current word outside the written lanes. Inside them it takes the request data shifted left by 8 × `req_addr[1:0]` bits. The lane count is 1 for `req_size` 0, 2 for 1 and 4 for 2 or 3, and lanes that would land above byte 3 are discarded.
- R6: A write whose word-aligned address is 0x60–0x6F or 0x74–0x7F sets no strobe.
- R7: An accepted read raises `rsp_valid` for exactly the next cycle. `rsp_rdata` is then the fetched word shifted right by 8 × `req_addr[1:0]` bits and masked to 8, 16 or 32 bits for `req_size` 0, 1, or 2/3.
- R8: A read is mapped to the core file below 0x40 and to the DMA file from 0x40 to 0x5F, and to the control register only when the address is exactly 0x70. Any other read address, including 0x71–0x73, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address in the window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata | input | 32 | Write data, lane 0 in bits [7:0] |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, aligned to lane 0 |
| rd_idx | output | 4 | Word index on the back-end read port |
| core_rd_data | input | 32 | Core file word at `rd_idx` |
| dma_rd_data | input | 32 | DMA file word at `rd_idx` |
| ctl_rd_data | input | 32 | Control register word |
| core_wr_en | output | 1 | Write strobe, core file |
| dma_wr_en | output | 1 | Write strobe, DMA file |
| ctl_wr_en | output | 1 | Write strobe, control register |
| wr_idx | output | 4 | Word index of the write |
| wr_data | output | 32 | Full word to write |

## Verification
A wrong state bit or a stale capture register shows up at the ports within two cycles of the request. It appears as a strobe on the wrong target or one cycle early or late, as a `req_ready` that does not drop for a merge, or as a written word whose untouched lanes differ from what was there before. Because back-end storage is kept outside the block, a corrupted merge stays in place. A later whole-word read of that address exposes it, so the sweep reads every word back after writing every address at every size. Read alignment faults appear on `rsp_rdata` one cycle after the read is accepted.

// File: rtl/subword_bridge_pkg.sv
package subword_bridge_pkg;

    localparam int DATA_W     = 32;
    localparam int BYTES      = DATA_W / 8;
    localparam int OFF_W      = $clog2(BYTES);
    localparam int WINDOW     = 128;
    localparam int ADDR_W     = $clog2(WINDOW);
    localparam int CORE_LIMIT = 64;
    localparam int DMA_LIMIT  = 96;
    localparam int CTL_BYTE   = 112;
    localparam int IDX_W      = $clog2(CORE_LIMIT / BYTES);
    localparam int SH_W       = OFF_W + 3;

    localparam logic [ADDR_W-1:0] CORE_LIMIT_A = ADDR_W'(CORE_LIMIT);
    localparam logic [ADDR_W-1:0] DMA_LIMIT_A  = ADDR_W'(DMA_LIMIT);
    localparam logic [ADDR_W-1:0] CTL_A        = ADDR_W'(CTL_BYTE);

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CORE = 2'd1,
        RGN_DMA  = 2'd2,
        RGN_CTL  = 2'd3
    } region_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_MERGE = 1'b1
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        logic [DATA_W-1:0] wdata;
    } pend_t;

    typedef struct packed {
        region_e           region;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        if (a < CORE_LIMIT_A)     return RGN_CORE;
        else if (a < DMA_LIMIT_A) return RGN_DMA;
        else if (a == CTL_A)      return RGN_CTL;
        else                      return RGN_NONE;
    endfunction

    function automatic logic [IDX_W-1:0] index_of(input logic [ADDR_W-1:0] a,
                                                  input region_e r);
        logic [ADDR_W-1:0] rel;
        rel = (r == RGN_DMA) ? (a - CORE_LIMIT_A) : a;
        if (r == RGN_CORE || r == RGN_DMA) return IDX_W'(rel >> OFF_W);
        else                               return '0;
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        logic [DATA_W-1:0] m;
        unique case (sz)
            2'd0:    m = {{(DATA_W-8){1'b0}}, 8'hFF};
            2'd1:    m = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic is_full_word(input logic [1:0] sz,
                                          input logic [OFF_W-1:0] off);
        return sz[1] && (off == '0);
    endfunction

    function automatic logic [SH_W-1:0] lane_shift(input logic [OFF_W-1:0] off);
        return {off, 3'b000};
    endfunction

endpackage

// File: rtl/bridge_region_decode.sv
module bridge_region_decode
    import subword_bridge_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        region = region_of(addr);
        idx    = index_of(addr, region);
    end
endmodule

// File: rtl/bridge_lane_merge.sv
module bridge_lane_merge
    import subword_bridge_pkg::*;
(
    input  logic [DATA_W-1:0] cur_word,
    input  logic [DATA_W-1:0] new_data,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] lanes;
    logic [DATA_W-1:0] placed;

    always_comb begin
        lanes  = size_mask(size) << lane_shift(off);
        placed = new_data << lane_shift(off);
        merged = (cur_word & ~lanes) | (placed & lanes);
    end
endmodule

// File: rtl/bridge_read_align.sv
module bridge_read_align
    import subword_bridge_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] data
);
    always_comb data = (word >> lane_shift(off)) & size_mask(size);
endmodule

// File: rtl/subword_reg_bridge.sv
module subword_reg_bridge
    import subword_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] core_rd_data,
    input  logic [DATA_W-1:0] dma_rd_data,
    input  logic [DATA_W-1:0] ctl_rd_data,
    output logic              core_wr_en,
    output logic              dma_wr_en,
    output logic              ctl_wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    state_e            state_q;
    pend_t             pend_q;
    wr_cmd_t           wr_q;
    logic              accept;
    logic              merging;
    logic [ADDR_W-1:0] src_addr;
    region_e           src_region;
    logic [IDX_W-1:0]  src_idx;
    logic [DATA_W-1:0] fetched;
    logic [DATA_W-1:0] merged_word;
    logic [DATA_W-1:0] read_lanes;

    assign merging   = (state_q == ST_MERGE);
    assign req_ready = !merging;
    assign accept    = req_valid && req_ready;

    // During a merge the port looks at the captured word address; otherwise
    // at the live request (exact address, so read holes decode as such).
    assign src_addr = merging ? {pend_q.addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                              : req_addr;

    bridge_region_decode decode_i (
        .addr   (src_addr),
        .region (src_region),
        .idx    (src_idx)
    );

    assign rd_idx = src_idx;

    always_comb begin
        unique case (src_region)
            RGN_CORE: fetched = core_rd_data;
            RGN_DMA:  fetched = dma_rd_data;
            RGN_CTL:  fetched = ctl_rd_data;
            default:  fetched = '0;
        endcase
    end

    bridge_lane_merge merge_i (
        .cur_word (fetched),
        .new_data (pend_q.wdata),
        .off      (pend_q.addr[OFF_W-1:0]),
        .size     (pend_q.size),
        .merged   (merged_word)
    );

    bridge_read_align align_i (
        .word (fetched),
        .off  (req_addr[OFF_W-1:0]),
        .size (req_size),
        .data (read_lanes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pend_q    <= '0;
            wr_q      <= '{region: RGN_NONE, idx: '0, data: '0};
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            wr_q.region <= RGN_NONE;
            rsp_valid   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (!req_write) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= read_lanes;
                        end else if (is_full_word(req_size, req_addr[OFF_W-1:0])) begin
                            wr_q <= '{region: src_region, idx: src_idx, data: req_wdata};
                        end else begin
                            pend_q  <= '{addr: req_addr, size: req_size, wdata: req_wdata};
                            state_q <= ST_MERGE;
                        end
                    end
                end
                ST_MERGE: begin
                    wr_q    <= '{region: src_region, idx: src_idx, data: merged_word};
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign core_wr_en = (wr_q.region == RGN_CORE);
    assign dma_wr_en  = (wr_q.region == RGN_DMA);
    assign ctl_wr_en  = (wr_q.region == RGN_CTL);
    assign wr_idx     = wr_q.idx;
    assign wr_data    = wr_q.data;

endmodule

// File: rtl/subword_reg_bridge_checker.sv
module subword_reg_bridge_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [6:0]  req_addr,
    input logic [1:0]  req_size,
    input logic [31:0] req_wdata,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        core_wr_en,
    input logic        dma_wr_en,
    input logic        ctl_wr_en,
    input logic [3:0]  wr_idx,
    input logic [31:0] wr_data
);
    logic acc_wr, acc_rd, full, any_wr, hole_wr, hole_rd;

    assign acc_wr  = req_valid && req_ready && req_write;
    assign acc_rd  = req_valid && req_ready && !req_write;
    assign full    = req_size[1] && (req_addr[1:0] == 2'b00);
    assign any_wr  = core_wr_en || dma_wr_en || ctl_wr_en;
    assign hole_wr = (req_addr >= 7'h60 && req_addr < 7'h70) || (req_addr >= 7'h74);
    assign hole_rd = (req_addr >= 7'h60) && (req_addr != 7'h70);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !any_wr));

    assert_full_write_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && full && req_addr < 7'h40) |=>
        (core_wr_en && req_ready && wr_data == $past(req_wdata)
         && wr_idx == $past(req_addr[5:2])));

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({core_wr_en, dma_wr_en, ctl_wr_en}));

    assert_merge_stall_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !full) |=> (!req_ready && !any_wr));

    assert_hole_full_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && full && hole_wr) |=> !any_wr);

    assert_hole_merge_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && !full && hole_wr) |=> ##1 !any_wr);

    assert_read_resp_R7: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> rsp_valid);

    assert_no_spurious_rsp_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(acc_rd));

    assert_byte_read_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && req_size == 2'd0) |=> (rsp_rdata[31:8] == 24'd0));

    assert_hole_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && hole_rd) |=> (rsp_rdata == 32'd0));

endmodule

bind subword_reg_bridge subword_reg_bridge_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .core_wr_en (core_wr_en),
    .dma_wr_en  (dma_wr_en),
    .ctl_wr_en  (ctl_wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data)
);

// File: tb/subword_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module subword_reg_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  rd_idx;
    logic [31:0] core_rd_data, dma_rd_data, ctl_rd_data;
    logic        core_wr_en, dma_wr_en, ctl_wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;

    always #2.5 clk = ~clk;

    subword_reg_bridge dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rd_idx(rd_idx),
        .core_rd_data(core_rd_data), .dma_rd_data(dma_rd_data),
        .ctl_rd_data(ctl_rd_data),
        .core_wr_en(core_wr_en), .dma_wr_en(dma_wr_en), .ctl_wr_en(ctl_wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // Back-end storage, outside the block under test.
    logic [31:0] core_m [16];
    logic [31:0] dma_m  [8];
    logic [31:0] ctl_m;
    // Bench's own expectation of the storage.
    logic [31:0] exp_core [16];
    logic [31:0] exp_dma  [8];
    logic [31:0] exp_ctl;

    function automatic logic [31:0] seed_word(input int r, input int i);
        return (32'h1000_0000 * (r + 1)) ^ (i * 32'h0101_0101) ^ 32'h00C3_5A00;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) core_m[i] <= seed_word(0, i);
            for (int i = 0; i < 8; i++)  dma_m[i]  <= seed_word(1, i);
            ctl_m <= seed_word(2, 0);
        end else begin
            if (core_wr_en) core_m[wr_idx] <= wr_data;
            if (dma_wr_en)  dma_m[wr_idx[2:0]] <= wr_data;
            if (ctl_wr_en)  ctl_m <= wr_data;
        end
    end

    assign core_rd_data = core_m[rd_idx];
    assign dma_rd_data  = dma_m[rd_idx[2:0]];
    assign ctl_rd_data  = ctl_m;

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] mask_of(input logic [1:0] sz);
        return (nbytes(sz) == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nbytes(sz))) - 32'd1);
    endfunction

    // Region code: 0 hole, 1 core, 2 dma, 3 control.
    function automatic int rgn(input int a);
        if (a < 64) return 1;
        if (a < 96) return 2;
        if (a == 112) return 3;
        return 0;
    endfunction

    function automatic int idx_of(input int a);
        if (a < 64) return a / 4;
        if (a < 96) return (a - 64) / 4;
        return 0;
    endfunction

    function automatic logic [31:0] model_word(input int r, input int i);
        case (r)
            1: return exp_core[i];
            2: return exp_dma[i];
            3: return exp_ctl;
            default: return 32'd0;
        endcase
    endfunction

    task automatic do_write(input int a, input logic [1:0] sz, input logic [31:0] d);
        int off, wa, r, i;
        bit full;
        logic [31:0] m, nw;
        off  = a % 4;
        wa   = a - off;
        r    = rgn(wa);
        i    = idx_of(wa);
        full = (nbytes(sz) == 4) && (off == 0);
        m    = mask_of(sz) << (8 * off);
        nw   = full ? d : ((model_word(r, i) & ~m) | ((d << (8 * off)) & m));
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 7'(a);
        req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        if (full) begin
            check(req_ready == 1'b1, "R2 ready stays high", 32'(req_ready), 32'd1);
        end else begin
            check(req_ready == 1'b0 && !(core_wr_en || dma_wr_en || ctl_wr_en),
                  "R4 stall cycle", {28'd0, req_ready, core_wr_en, dma_wr_en, ctl_wr_en},
                  32'd0);
            @(negedge clk);
        end
        check({core_wr_en, dma_wr_en, ctl_wr_en} ==
                  ((r == 1) ? 3'b100 : (r == 2) ? 3'b010 : (r == 3) ? 3'b001 : 3'b000),
              (r == 0) ? "R6 hole write strobe" : "R3 write target",
              {29'd0, core_wr_en, dma_wr_en, ctl_wr_en}, 32'(r));
        if (r != 0) begin
            check(wr_idx == 4'(i), "R3 write index", 32'(wr_idx), 32'(i));
            check(wr_data == nw, full ? "R2 word data" : "R5 merged data", wr_data, nw);
            case (r)
                1: exp_core[i] = nw;
                2: exp_dma[i]  = nw;
                default: exp_ctl = nw;
            endcase
        end
    endtask

    task automatic do_read(input int a, input logic [1:0] sz);
        int off, r;
        logic [31:0] e;
        off = a % 4;
        r   = rgn(a);
        e   = (model_word(r, idx_of(a)) >> (8 * off)) & mask_of(sz);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 7'(a); req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R7 rsp_valid", 32'(rsp_valid), 32'd1);
        check(rsp_rdata == e, (r == 0) ? "R8 read map/hole" : "R7 read align",
              rsp_rdata, e);
    endtask

    bit done = 1'b0;

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_core[i] = seed_word(0, i);
        for (int i = 0; i < 8; i++)  exp_dma[i]  = seed_word(1, i);
        exp_ctl = seed_word(2, 0);

        repeat (4) @(negedge clk);
        check(req_ready && !rsp_valid && !(core_wr_en || dma_wr_en || ctl_wr_en),
              "R1 during reset", {29'd0, req_ready, rsp_valid, core_wr_en}, 32'd4);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !rsp_valid && !(core_wr_en || dma_wr_en || ctl_wr_en),
              "R1 after reset", {29'd0, req_ready, rsp_valid, core_wr_en}, 32'd4);

        // R7 / R8: every address at every size against the seeded contents.
        for (int a = 0; a < 128; a++)
            for (int s = 0; s < 4; s++) do_read(a, 2'(s));

        // R2..R6: every address at every size code, distinct data each time.
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 128; a++)
                do_write(a, 2'(s), 32'hA55A_0000 ^ (a * 32'h0103_0507) ^ (s * 32'h1111_0000));

        // Read back every word and a few narrow views of the merged contents.
        for (int a = 0; a < 128; a += 4) do_read(a, 2'd2);
        for (int a = 0; a < 128; a++) do_read(a, 2'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule